// File: doc/BRIEF.md
# Variable refresh vertical limit calculator

This block converts a display mode and a monitor's refresh range into the vertical-total limits used by a variable-refresh scan-out engine. A one-cycle start pulse captures the pixel clock (in kHz), the horizontal and vertical totals, the active line count, the refresh floor and ceiling (in Hz) and four qualifier bits. The block then produces the shortest and longest allowed frame lengths in lines, the flip line, and one pipeline timing field. A mode input selects that field: either a guardband or a legacy saturated pipeline-fill count.

Both divisions share one iterative restoring divider. The shortest frame uses a rounded-up quotient and the longest uses a rounded-down one. Each is then raised to the mode's fixed vertical total. The enable output rises only when the sink, the mode and the user all permit variable refresh and the resulting window is non-empty. A done strobe marks each new result, and the outputs hold steady between strobes.

Top module: `vrr_limits`

## Requirements
- R1: en_o is 1 only when sink_cap_i=1, interlace_i=0, user_en_i=1, rate_max_i − rate_min_i > 10, and htotal_i, rate_min_i and rate_max_i are all nonzero.
- R2: The raw shortest frame is ceil(clk_khz_i·1000 / (htotal_i·rate_max_i)), saturated at 2^VT_W−1 (65535 by default).
- R3: The raw longest frame is floor(clk_khz_i·1000 / (htotal_i·rate_min_i)), saturated at 2^VT_W−1.
- R4: Each raw value below vtotal_i is raised to vtotal_i. If the clamped shortest frame is greater than or equal to the clamped longest frame, en_o is 0.
- R5: With en_o=1, vmin_o is the clamped shortest frame minus one, flipline_o is vmin_o+1, and vmax_o is the clamped longest frame.
- R6: With gb_mode_i=1, guardband_o is vmin_o − vactive_i (0 if that is negative) and pipe_full_o is 0.
- R7: With gb_mode_i=0, pipe_full_o is vmin_o − vactive_i − 5, clamped to the range 0..255, and guardband_o is 0.
- R8: With en_o=0, vmin_o, vmax_o, flipline_o, guardband_o and pipe_full_o are all 0.
- R9: done_o is high for exactly one cycle, 2·DIV_W+4 rising edges (68 by default) after the edge that samples start_i. The outputs change only on that edge.
- R10: All inputs are captured on the edge that samples start_i. A start pulse while a calculation runs is ignored: it produces no extra done_o and does not alter the result.
- R11: After reset, every output is 0 and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a calculation; sampled while idle |
| clk_khz_i | input | CLK_W | Pixel clock in kHz |
| htotal_i | input | HT_W | Horizontal total in pixels |
| vtotal_i | input | VT_W | Fixed vertical total of the mode |
| vactive_i | input | VT_W | Active line count |
| rate_min_i | input | RATE_W | Lowest refresh rate in Hz |
| rate_max_i | input | RATE_W | Highest refresh rate in Hz |
| interlace_i | input | 1 | Mode is interlaced |
| user_en_i | input | 1 | User request for variable refresh |
| sink_cap_i | input | 1 | Sink accepts video without fixed timing attributes |
| gb_mode_i | input | 1 | 1 selects guardband, 0 selects pipeline-fill |
| en_o | output | 1 | Variable refresh permitted with these limits |
| vmin_o | output | VT_W | Shortest frame field (clamped minimum − 1) |
| vmax_o | output | VT_W | Longest frame in lines |
| flipline_o | output | VT_W | Flip line |
| guardband_o | output | VT_W | Guardband lines (guardband mode only) |
| pipe_full_o | output | PIPE_W | Saturated pipeline-fill count (legacy mode only) |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions assume that vactive_i stays below vtotal_i for meaningful guardband values, and that clk_khz_i·1000 fits the divider width. The second assumption holds for any CLK_W-bit clock at the default sizes. The remainder bound inside the divider is checked only while the captured divisor is nonzero, because a zero divisor is qualified away rather than prevented. The stimulus sweeps pixel clocks up to the full 20-bit range, several horizontal totals including 0 and 1, and several refresh pairs including a zero floor and a spread of exactly 10 Hz. It always keeps the active count below the vertical total. Separate runs flip each qualifier bit and inject a second start mid-calculation.

// File: rtl/vrr_limits_pkg.sv
`timescale 1ns/1ps
package vrr_limits_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOAD    = 3'd1,
    ST_DIV_MIN = 3'd2,
    ST_DIV_MAX = 3'd3,
    ST_FIN     = 3'd4
  } calc_state_t;

  localparam int unsigned KHZ_TO_HZ   = 1000;
  localparam int unsigned SPREAD_HZ   = 10;
  localparam int unsigned PIPE_MARGIN = 5;

endpackage

// File: rtl/vrr_limits_div.sv
`timescale 1ns/1ps
module vrr_limits_div #(
  parameter int unsigned DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] num_i,
  input  logic [DIV_W-1:0] den_i,
  output logic             done_o,
  output logic [DIV_W-1:0] quo_o,
  output logic [DIV_W-1:0] rem_o
);
  localparam int unsigned CNT_W = $clog2(DIV_W + 1);

  logic [DIV_W-1:0] rem_q, rem_d;
  logic [DIV_W-1:0] quo_q, quo_d;
  logic [DIV_W-1:0] den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [DIV_W:0]   trial;

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    trial  = {rem_q, quo_q[DIV_W-1]};
    if (start_i) begin
      rem_d = '0;
      quo_d = num_i;
      den_d = den_i;
      cnt_d = CNT_W'(DIV_W);
    end else if (cnt_q != '0) begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = DIV_W'(trial - {1'b0, den_q});
        quo_d = {quo_q[DIV_W-2:0], 1'b1};
      end else begin
        rem_d = trial[DIV_W-1:0];
        quo_d = {quo_q[DIV_W-2:0], 1'b0};
      end
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  // Partial remainder never reaches the divisor while iterating (R2, R3)
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != '0) && (den_q != '0)) |-> (rem_q < den_q));

endmodule

// File: rtl/vrr_limits_eval.sv
`timescale 1ns/1ps
module vrr_limits_eval
  import vrr_limits_pkg::*;
#(
  parameter int unsigned DIV_W  = 32,
  parameter int unsigned HT_W   = 16,
  parameter int unsigned VT_W   = 16,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned PIPE_W = 8
) (
  input  logic [DIV_W-1:0]  quo_min_i,
  input  logic              rem_min_nz_i,
  input  logic [DIV_W-1:0]  quo_max_i,
  input  logic [HT_W-1:0]   htotal_i,
  input  logic [VT_W-1:0]   vtotal_i,
  input  logic [VT_W-1:0]   vactive_i,
  input  logic [RATE_W-1:0] rate_min_i,
  input  logic [RATE_W-1:0] rate_max_i,
  input  logic              interlace_i,
  input  logic              user_en_i,
  input  logic              sink_cap_i,
  input  logic              gb_mode_i,
  output logic              en_o,
  output logic [VT_W-1:0]   vmin_o,
  output logic [VT_W-1:0]   vmax_o,
  output logic [VT_W-1:0]   flip_o,
  output logic [VT_W-1:0]   gb_o,
  output logic [PIPE_W-1:0] pipe_o
);
  localparam logic [DIV_W:0] SAT_LIM  = {{(DIV_W + 1 - VT_W){1'b0}}, {VT_W{1'b1}}};
  localparam logic [VT_W:0]  PIPE_MAX = {{(VT_W + 1 - PIPE_W){1'b0}}, {PIPE_W{1'b1}}};

  logic [DIV_W:0]  ceil_w, floor_w;
  logic [VT_W-1:0] sat_min, sat_max, clamp_min, clamp_max, vmin_n;
  logic [RATE_W:0] rate_floor_ext;
  logic            spread_ok, divisors_ok, qualified, window_ok;
  logic [VT_W:0]   pipe_floor, pipe_diff;

  always_comb begin
    ceil_w  = {1'b0, quo_min_i} + (DIV_W + 1)'(rem_min_nz_i);
    floor_w = {1'b0, quo_max_i};
    sat_min = (ceil_w  > SAT_LIM) ? SAT_LIM[VT_W-1:0] : ceil_w[VT_W-1:0];
    sat_max = (floor_w > SAT_LIM) ? SAT_LIM[VT_W-1:0] : floor_w[VT_W-1:0];
    clamp_min = (sat_min < vtotal_i) ? vtotal_i : sat_min;
    clamp_max = (sat_max < vtotal_i) ? vtotal_i : sat_max;

    rate_floor_ext = {1'b0, rate_min_i} + (RATE_W + 1)'(SPREAD_HZ);
    spread_ok      = ({1'b0, rate_max_i} > rate_floor_ext);
    divisors_ok    = (htotal_i != '0) && (rate_min_i != '0) && (rate_max_i != '0);
    qualified      = sink_cap_i && !interlace_i && user_en_i && spread_ok && divisors_ok;
    window_ok      = clamp_min < clamp_max;

    vmin_n     = clamp_min - 1'b1;
    pipe_floor = {1'b0, vactive_i} + (VT_W + 1)'(PIPE_MARGIN);
    pipe_diff  = {1'b0, vmin_n} - pipe_floor;

    en_o   = qualified && window_ok;
    vmin_o = '0;
    vmax_o = '0;
    flip_o = '0;
    gb_o   = '0;
    pipe_o = '0;
    if (en_o) begin
      vmin_o = vmin_n;
      vmax_o = clamp_max;
      flip_o = clamp_min;
      if (gb_mode_i) begin
        gb_o = (vmin_n >= vactive_i) ? (vmin_n - vactive_i) : '0;
      end else if ({1'b0, vmin_n} >= pipe_floor) begin
        pipe_o = (pipe_diff > PIPE_MAX) ? PIPE_MAX[PIPE_W-1:0] : pipe_diff[PIPE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/vrr_limits_ctrl.sv
`timescale 1ns/1ps
module vrr_limits_ctrl
  import vrr_limits_pkg::*;
#(
  parameter int unsigned DIV_W  = 32,
  parameter int unsigned CLK_W  = 20,
  parameter int unsigned HT_W   = 16,
  parameter int unsigned VT_W   = 16,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned PIPE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CLK_W-1:0]  clk_khz_i,
  input  logic [HT_W-1:0]   htotal_i,
  input  logic [VT_W-1:0]   vtotal_i,
  input  logic [VT_W-1:0]   vactive_i,
  input  logic [RATE_W-1:0] rate_min_i,
  input  logic [RATE_W-1:0] rate_max_i,
  input  logic              interlace_i,
  input  logic              user_en_i,
  input  logic              sink_cap_i,
  input  logic              gb_mode_i,
  // divider side
  input  logic              div_done_i,
  input  logic [DIV_W-1:0]  div_quo_i,
  input  logic [DIV_W-1:0]  div_rem_i,
  output logic              div_start_o,
  output logic [DIV_W-1:0]  div_num_o,
  output logic [DIV_W-1:0]  div_den_o,
  // evaluator side
  output logic [DIV_W-1:0]  cap_quo_min_o,
  output logic              cap_rem_nz_o,
  output logic [HT_W-1:0]   cap_htotal_o,
  output logic [VT_W-1:0]   cap_vtotal_o,
  output logic [VT_W-1:0]   cap_vactive_o,
  output logic [RATE_W-1:0] cap_rate_min_o,
  output logic [RATE_W-1:0] cap_rate_max_o,
  output logic              cap_interlace_o,
  output logic              cap_user_en_o,
  output logic              cap_sink_cap_o,
  output logic              cap_gb_mode_o,
  input  logic              ev_en_i,
  input  logic [VT_W-1:0]   ev_vmin_i,
  input  logic [VT_W-1:0]   ev_vmax_i,
  input  logic [VT_W-1:0]   ev_flip_i,
  input  logic [VT_W-1:0]   ev_gb_i,
  input  logic [PIPE_W-1:0] ev_pipe_i,
  // results
  output logic              en_o,
  output logic [VT_W-1:0]   vmin_o,
  output logic [VT_W-1:0]   vmax_o,
  output logic [VT_W-1:0]   flipline_o,
  output logic [VT_W-1:0]   guardband_o,
  output logic [PIPE_W-1:0] pipe_full_o,
  output logic              done_o
);
  calc_state_t state_q, state_d;

  logic [CLK_W-1:0]  clk_q;
  logic [HT_W-1:0]   ht_q;
  logic [VT_W-1:0]   vt_q, va_q;
  logic [RATE_W-1:0] rmin_q, rmax_q;
  logic              il_q, ue_q, cap_q, gbm_q;
  logic [DIV_W-1:0]  qmin_q;
  logic              rnz_q;
  logic              en_q, done_q;
  logic [VT_W-1:0]   vmin_q, vmax_q, flip_q, gb_q;
  logic [PIPE_W-1:0] pipe_q;

  logic capture_en, qmin_en, result_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i)    state_d = ST_LOAD;
      ST_LOAD:                    state_d = ST_DIV_MIN;
      ST_DIV_MIN: if (div_done_i) state_d = ST_DIV_MAX;
      ST_DIV_MAX: if (div_done_i) state_d = ST_FIN;
      ST_FIN:                     state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  assign capture_en  = (state_q == ST_IDLE) && start_i;
  assign qmin_en     = (state_q == ST_DIV_MIN) && div_done_i;
  assign result_en   = (state_q == ST_FIN);
  assign div_start_o = (state_q == ST_LOAD) || qmin_en;
  assign div_num_o   = DIV_W'(clk_q) * DIV_W'(KHZ_TO_HZ);
  assign div_den_o   = (state_q == ST_LOAD) ? DIV_W'(ht_q) * DIV_W'(rmax_q)
                                            : DIV_W'(ht_q) * DIV_W'(rmin_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      clk_q   <= '0;
      ht_q    <= '0;
      vt_q    <= '0;
      va_q    <= '0;
      rmin_q  <= '0;
      rmax_q  <= '0;
      il_q    <= 1'b0;
      ue_q    <= 1'b0;
      cap_q   <= 1'b0;
      gbm_q   <= 1'b0;
      qmin_q  <= '0;
      rnz_q   <= 1'b0;
      en_q    <= 1'b0;
      vmin_q  <= '0;
      vmax_q  <= '0;
      flip_q  <= '0;
      gb_q    <= '0;
      pipe_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= result_en;
      if (capture_en) begin
        clk_q  <= clk_khz_i;
        ht_q   <= htotal_i;
        vt_q   <= vtotal_i;
        va_q   <= vactive_i;
        rmin_q <= rate_min_i;
        rmax_q <= rate_max_i;
        il_q   <= interlace_i;
        ue_q   <= user_en_i;
        cap_q  <= sink_cap_i;
        gbm_q  <= gb_mode_i;
      end
      if (qmin_en) begin
        qmin_q <= div_quo_i;
        rnz_q  <= (div_rem_i != '0);
      end
      if (result_en) begin
        en_q   <= ev_en_i;
        vmin_q <= ev_vmin_i;
        vmax_q <= ev_vmax_i;
        flip_q <= ev_flip_i;
        gb_q   <= ev_gb_i;
        pipe_q <= ev_pipe_i;
      end
    end
  end

  assign cap_quo_min_o   = qmin_q;
  assign cap_rem_nz_o    = rnz_q;
  assign cap_htotal_o    = ht_q;
  assign cap_vtotal_o    = vt_q;
  assign cap_vactive_o   = va_q;
  assign cap_rate_min_o  = rmin_q;
  assign cap_rate_max_o  = rmax_q;
  assign cap_interlace_o = il_q;
  assign cap_user_en_o   = ue_q;
  assign cap_sink_cap_o  = cap_q;
  assign cap_gb_mode_o   = gbm_q;

  assign en_o        = en_q;
  assign vmin_o      = vmin_q;
  assign vmax_o      = vmax_q;
  assign flipline_o  = flip_q;
  assign guardband_o = gb_q;
  assign pipe_full_o = pipe_q;
  assign done_o      = done_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_FIN) |=> ($stable(en_q) && $stable(vmin_q) && $stable(vmax_q)
                             && $stable(gb_q) && $stable(pipe_q)));

  assert_window_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (vmin_q < vmax_q));

  assert_off_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> ((vmin_q == '0) && (vmax_q == '0) && (flip_q == '0)
               && (gb_q == '0) && (pipe_q == '0)));

  assert_one_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((gb_q != '0) && (pipe_q != '0)));

  assert_busy_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(vt_q) && $stable(clk_q) && $stable(rmin_q)));

endmodule

// File: rtl/vrr_limits.sv
`timescale 1ns/1ps
module vrr_limits
  import vrr_limits_pkg::*;
#(
  parameter int unsigned CLK_W  = 20,
  parameter int unsigned HT_W   = 16,
  parameter int unsigned VT_W   = 16,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned PIPE_W = 8,
  parameter int unsigned DIV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CLK_W-1:0]  clk_khz_i,
  input  logic [HT_W-1:0]   htotal_i,
  input  logic [VT_W-1:0]   vtotal_i,
  input  logic [VT_W-1:0]   vactive_i,
  input  logic [RATE_W-1:0] rate_min_i,
  input  logic [RATE_W-1:0] rate_max_i,
  input  logic              interlace_i,
  input  logic              user_en_i,
  input  logic              sink_cap_i,
  input  logic              gb_mode_i,
  output logic              en_o,
  output logic [VT_W-1:0]   vmin_o,
  output logic [VT_W-1:0]   vmax_o,
  output logic [VT_W-1:0]   flipline_o,
  output logic [VT_W-1:0]   guardband_o,
  output logic [PIPE_W-1:0] pipe_full_o,
  output logic              done_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  logic              div_start, div_done;
  logic [DIV_W-1:0]  div_num, div_den, div_quo, div_rem;
  logic [DIV_W-1:0]  cap_qmin;
  logic              cap_rnz, cap_il, cap_ue, cap_sink, cap_gbm;
  logic [HT_W-1:0]   cap_ht;
  logic [VT_W-1:0]   cap_vt, cap_va;
  logic [RATE_W-1:0] cap_rmin, cap_rmax;
  logic              ev_en;
  logic [VT_W-1:0]   ev_vmin, ev_vmax, ev_flip, ev_gb;
  logic [PIPE_W-1:0] ev_pipe;

  vrr_limits_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .done_o  (div_done),
    .quo_o   (div_quo),
    .rem_o   (div_rem)
  );

  vrr_limits_eval #(
    .DIV_W(DIV_W), .HT_W(HT_W), .VT_W(VT_W), .RATE_W(RATE_W), .PIPE_W(PIPE_W)
  ) u_eval (
    .quo_min_i    (cap_qmin),
    .rem_min_nz_i (cap_rnz),
    .quo_max_i    (div_quo),
    .htotal_i     (cap_ht),
    .vtotal_i     (cap_vt),
    .vactive_i    (cap_va),
    .rate_min_i   (cap_rmin),
    .rate_max_i   (cap_rmax),
    .interlace_i  (cap_il),
    .user_en_i    (cap_ue),
    .sink_cap_i   (cap_sink),
    .gb_mode_i    (cap_gbm),
    .en_o         (ev_en),
    .vmin_o       (ev_vmin),
    .vmax_o       (ev_vmax),
    .flip_o       (ev_flip),
    .gb_o         (ev_gb),
    .pipe_o       (ev_pipe)
  );

  vrr_limits_ctrl #(
    .DIV_W(DIV_W), .CLK_W(CLK_W), .HT_W(HT_W), .VT_W(VT_W),
    .RATE_W(RATE_W), .PIPE_W(PIPE_W)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n_int),
    .start_i         (start_i),
    .clk_khz_i       (clk_khz_i),
    .htotal_i        (htotal_i),
    .vtotal_i        (vtotal_i),
    .vactive_i       (vactive_i),
    .rate_min_i      (rate_min_i),
    .rate_max_i      (rate_max_i),
    .interlace_i     (interlace_i),
    .user_en_i       (user_en_i),
    .sink_cap_i      (sink_cap_i),
    .gb_mode_i       (gb_mode_i),
    .div_done_i      (div_done),
    .div_quo_i       (div_quo),
    .div_rem_i       (div_rem),
    .div_start_o     (div_start),
    .div_num_o       (div_num),
    .div_den_o       (div_den),
    .cap_quo_min_o   (cap_qmin),
    .cap_rem_nz_o    (cap_rnz),
    .cap_htotal_o    (cap_ht),
    .cap_vtotal_o    (cap_vt),
    .cap_vactive_o   (cap_va),
    .cap_rate_min_o  (cap_rmin),
    .cap_rate_max_o  (cap_rmax),
    .cap_interlace_o (cap_il),
    .cap_user_en_o   (cap_ue),
    .cap_sink_cap_o  (cap_sink),
    .cap_gb_mode_o   (cap_gbm),
    .ev_en_i         (ev_en),
    .ev_vmin_i       (ev_vmin),
    .ev_vmax_i       (ev_vmax),
    .ev_flip_i       (ev_flip),
    .ev_gb_i         (ev_gb),
    .ev_pipe_i       (ev_pipe),
    .en_o            (en_o),
    .vmin_o          (vmin_o),
    .vmax_o          (vmax_o),
    .flipline_o      (flipline_o),
    .guardband_o     (guardband_o),
    .pipe_full_o     (pipe_full_o),
    .done_o          (done_o)
  );

endmodule

// File: tb/test_vrr_limits.sv
`timescale 1ns/1ps
module test_vrr_limits;
  localparam int DIV_W   = 32;
  localparam int VT_W    = 16;
  localparam longint SAT = (64'd1 << VT_W) - 1;
  localparam int LAT     = 2 * DIV_W + 4;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [19:0] clk_khz;
  logic [15:0] htotal, vtotal, vactive;
  logic [7:0]  rate_min, rate_max;
  logic        il, ue, cap, gbm;
  logic        en, done;
  logic [15:0] vmin, vmax, flip, gb;
  logic [7:0]  pipe;

  int n_checks = 0;
  int n_fail   = 0;

  longint e_en, e_vmin, e_vmax, e_flip, e_gb, e_pipe;

  always #2.5 clk = ~clk;

  vrr_limits i_vrr_limits (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .clk_khz_i(clk_khz), .htotal_i(htotal), .vtotal_i(vtotal), .vactive_i(vactive),
    .rate_min_i(rate_min), .rate_max_i(rate_max),
    .interlace_i(il), .user_en_i(ue), .sink_cap_i(cap), .gb_mode_i(gbm),
    .en_o(en), .vmin_o(vmin), .vmax_o(vmax), .flipline_o(flip),
    .guardband_o(gb), .pipe_full_o(pipe), .done_o(done)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input longint c, input longint h, input longint vt, input longint va,
                       input longint rmn, input longint rmx,
                       input bit cp, input bit ilc, input bit uec, input bit gbc);
    longint num, qmn, qmx, cmn, cmx, d;
    bit ok;
    e_en = 0; e_vmin = 0; e_vmax = 0; e_flip = 0; e_gb = 0; e_pipe = 0;
    ok = cp && !ilc && uec && (rmx - rmn > 10) && h != 0 && rmn != 0 && rmx != 0;
    if (h != 0 && rmn != 0 && rmx != 0) begin
      num = c * 1000;
      qmn = (num + h * rmx - 1) / (h * rmx);
      qmx = num / (h * rmn);
      if (qmn > SAT) qmn = SAT;
      if (qmx > SAT) qmx = SAT;
      cmn = (qmn < vt) ? vt : qmn;
      cmx = (qmx < vt) ? vt : qmx;
      if (ok && cmn < cmx) begin
        e_en = 1; e_vmin = cmn - 1; e_vmax = cmx; e_flip = cmn;
        if (gbc) e_gb = (e_vmin >= va) ? e_vmin - va : 0;
        else begin
          d = e_vmin - va - 5;
          e_pipe = (d < 0) ? 0 : ((d > 255) ? 255 : d);
        end
      end
    end
  endtask

  task automatic compare_all();
    chk("R1 R4 en", en, e_en);
    chk("R2 R5 vmin", vmin, e_vmin);
    chk("R3 vmax", vmax, e_vmax);
    chk("R5 flipline", flip, e_flip);
    chk("R6 guardband", gb, e_gb);
    chk("R7 pipe_full", pipe, e_pipe);
    if (!e_en) chk("R8 all zero", vmin | vmax | flip | gb | pipe, 0);
  endtask

  task automatic run_calc(input longint c, input longint h, input longint vt, input longint va,
                          input longint rmn, input longint rmx,
                          input bit cp, input bit ilc, input bit uec, input bit gbc,
                          input bit poke);
    int lat, extra;
    model(c, h, vt, va, rmn, rmx, cp, ilc, uec, gbc);
    @(negedge clk);
    clk_khz = c[19:0]; htotal = h[15:0]; vtotal = vt[15:0]; vactive = va[15:0];
    rate_min = rmn[7:0]; rate_max = rmx[7:0];
    cap = cp; il = ilc; ue = uec; gbm = gbc; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R10: inputs change right after capture
    clk_khz = 20'd594000; htotal = 16'd4400; vtotal = 16'd700; gbm = ~gbc;
    lat = 0;
    do begin
      @(posedge clk); #1; lat++;
      if (poke && lat == 10) start = 1'b1;
      if (poke && lat == 11) start = 1'b0;
    end while (!done && lat < 400);
    chk("R9 latency", lat, LAT);
    compare_all();
    @(posedge clk); #1;
    chk("R9 single pulse", done, 0);
    if (poke) begin
      extra = 0;
      for (int k = 0; k < LAT + 10; k++) begin
        @(posedge clk); #1;
        if (done) extra++;
      end
      chk("R10 busy start ignored", extra, 0);
      compare_all();
    end
  endtask

  longint clk_l [5] = '{0, 25175, 148500, 594000, 1048575};
  longint ht_l  [4] = '{0, 1, 800, 2200};
  longint rmn_l [5] = '{48, 50, 0, 1, 40};
  longint rmx_l [5] = '{60, 60, 144, 75, 165};
  longint vt_l  [4] = '{525, 1125, 2250, 1125};
  longint va_l  [4] = '{480, 1080, 2160, 1124};

  initial begin
    #(64'd200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    clk_khz = '0; htotal = '0; vtotal = '0; vactive = '0;
    rate_min = '0; rate_max = '0; il = 0; ue = 0; cap = 0; gbm = 0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 en", en, 0);
    chk("R11 done", done, 0);
    chk("R11 vmin", vmin, 0);
    chk("R11 vmax", vmax, 0);
    chk("R11 flip", flip, 0);
    chk("R11 fields", gb | pipe, 0);

    // R1 qualifiers on a nominal mode, R4 clamp and empty window
    run_calc(148500, 2200, 1125, 1080, 48, 144, 1, 0, 1, 1, 0);
    run_calc(148500, 2200, 1125, 1080, 48, 144, 1, 0, 1, 0, 0);
    run_calc(148500, 2200, 1125, 1080, 48, 144, 0, 0, 1, 1, 0);
    run_calc(148500, 2200, 1125, 1080, 48, 144, 1, 1, 1, 1, 0);
    run_calc(148500, 2200, 1125, 1080, 48, 144, 1, 0, 0, 1, 0);
    run_calc(148500, 2200, 1125, 1080, 50, 60, 1, 0, 1, 1, 0);
    run_calc(148500, 2200, 1125, 1080, 49, 60, 1, 0, 1, 0, 0);
    run_calc(148500, 2200, 1500, 1080, 48, 60, 1, 0, 1, 1, 0);
    run_calc(148500, 2200, 1125, 200, 30, 60, 1, 0, 1, 0, 0);
    // R10 start during a running calculation
    run_calc(148500, 2200, 1125, 1080, 40, 120, 1, 0, 1, 0, 1);

    // Sweep (R2 R3 R4 R5 R6 R7)
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 5; r++)
          for (int v = 0; v < 4; v++)
            for (int m = 0; m < 2; m++)
              run_calc(clk_l[a], ht_l[b], vt_l[v], va_l[v], rmn_l[r], rmx_l[r],
                       1, 0, 1, m[0], 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule